// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This unit keeps two 16-bit data pointers for an 8-bit microcontroller core, together with a small auxiliary control byte. One select bit in that byte decides which pointer is live. The special-function-register (SFR) port and every pointer micro-operation from the core act only on the live pointer. The other pointer keeps its value untouched until the select bit changes.

The core reaches the unit through a plain 8-bit SFR port: an address, write data and a write strobe, with read data formed combinationally. It also drives three single-cycle micro-operation strobes: increment the live pointer, load it with a 16-bit immediate, and step the auxiliary byte as a read-modify-write increment. The unit always presents the live pointer as an address for external data moves. It also presents the live pointer plus the zero-extended accumulator, which serves as the code-byte address and the indirect jump target. All pins are plain control and data pins, with no handshake. The core decides when each strobe is valid, and the unit accepts every strobe in the cycle it is raised.

A boot-enable flag is sampled from two inputs while reset is held and is read-only afterwards.

Top module: `dptr_unit`

## Requirements
- R1: While reset is held, both pointers clear to 0000H and the select bit and user flag clear to 0. After reset, SFR reads of 82H and 83H return 00H and `ptr_addr` is 0000H.
- R2: The boot flag becomes 1 at reset when `boot_status` is nonzero or `boot_pin` is 1, and 0 otherwise. After reset it holds, whatever the inputs and SFR writes do.
- R3: Reading SFR A2H returns the select bit in bit 0, the user flag in bit 3 and the boot flag in bit 5. Bits 1, 2, 4, 6 and 7 read 0, and writes to them have no effect.
- R4: SFR 82H reads and writes the low byte of the selected pointer and 83H the high byte. Select 0 picks pointer 0 and select 1 picks pointer 1. The unselected pointer keeps its value.
- R5: `uop_inc` adds one to the selected pointer, wrapping from FFFFH to 0000H.
- R6: `uop_load` loads `uop_imm` into the selected pointer.
- R7: `sum_addr` equals `ptr_addr` plus `acc` zero-extended, taken modulo 2^16.
- R8: `aux_inc` toggles the select bit and leaves the user flag and boot flag unchanged.
- R9: If a pointer micro-operation and an SFR write to 82H or 83H occur in the same cycle, the micro-operation is applied and the SFR write is dropped.
- R10: If `uop_load` and `uop_inc` are both high, only the load is applied. If `aux_inc` and an SFR write to A2H are both high, only the increment is applied.
- R11: SFR addresses other than 82H, 83H and A2H read as 00H, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_status | input | 8 | Status byte sampled for the boot flag during reset |
| boot_pin | input | 1 | Hardware boot-entry condition sampled during reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| aux_inc | input | 1 | Read-modify-write increment of the auxiliary byte |
| uop_inc | input | 1 | Increment the selected pointer |
| uop_load | input | 1 | Load the selected pointer from `uop_imm` |
| uop_imm | input | 16 | Immediate for `uop_load` |
| acc | input | 8 | Accumulator value for the offset address |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr` |
| ptr_addr | output | 16 | Selected pointer |
| sum_addr | output | 16 | Selected pointer plus accumulator |

## Verification
Two pairs of operations can land in the same cycle. The first is an SFR byte write to the selected pointer together with a pointer increment or load. The second is an SFR write of the control byte together with its increment. The bench raises both strobes of a pair in one cycle and afterwards reads the pointer bytes or the control byte through the SFR port. The result must show the micro-operation's effect and no trace of the dropped write. The load-versus-increment pair is driven the same way and judged on `ptr_addr`.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int PTR_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int NUM_PTR  = 2;
  localparam int SEL_W    = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

  localparam logic [BYTE_W-1:0] SFR_PTR_LO = 8'h82;
  localparam logic [BYTE_W-1:0] SFR_PTR_HI = 8'h83;
  localparam logic [BYTE_W-1:0] SFR_AUX    = 8'hA2;

  localparam int SEL_BIT  = 0;
  localparam int ZERO_BIT = 2;
  localparam int FLAG_BIT = 3;
  localparam int BOOT_BIT = 5;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_LOAD = 2'd1,
    PTR_INCR = 2'd2,
    PTR_BYTE = 2'd3
  } ptr_op_e;
endpackage

// File: rtl/dptr_aux_reg.sv
module dptr_aux_reg
  import dptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] boot_status,
  input  logic              boot_pin,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              inc_en,
  output logic              sel_q,
  output logic              flag_q,
  output logic              boot_q,
  output logic [BYTE_W-1:0] rd_val
);
  logic [BYTE_W-1:0] next_byte;

  always_comb begin
    rd_val           = '0;
    rd_val[SEL_BIT]  = sel_q;
    rd_val[FLAG_BIT] = flag_q;
    rd_val[BOOT_BIT] = boot_q;
  end

  always_comb begin
    next_byte           = inc_en ? (rd_val + BYTE_W'(1)) : wr_data;
    next_byte[ZERO_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      flag_q <= 1'b0;
      boot_q <= (|boot_status) | boot_pin;
    end else if (inc_en || wr_en) begin
      sel_q  <= next_byte[SEL_BIT];
      flag_q <= next_byte[FLAG_BIT];
    end
  end
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
  import dptr_pkg::*;
#(
  parameter int W = PTR_W,
  parameter int N = NUM_PTR,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     sel,
  input  logic              load,
  input  logic [W-1:0]      imm,
  input  logic              inc,
  input  logic              byte_we,
  input  logic              byte_hi,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [W-1:0]      cur_ptr
);
  localparam int HI_LSB = W - BYTE_W;

  logic [W-1:0] ptr_q [N];
  ptr_op_e      op;

  always_comb begin
    if (load)         op = PTR_LOAD;
    else if (inc)     op = PTR_INCR;
    else if (byte_we) op = PTR_BYTE;
    else              op = PTR_HOLD;
  end

  for (genvar g = 0; g < N; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr_q[g] <= '0;
      end else if (sel == SW'(g)) begin
        case (op)
          PTR_LOAD: ptr_q[g] <= imm;
          PTR_INCR: ptr_q[g] <= ptr_q[g] + W'(1);
          PTR_BYTE: begin
            if (byte_hi) ptr_q[g][W-1:HI_LSB] <= byte_data;
            else         ptr_q[g][BYTE_W-1:0] <= byte_data;
          end
          default: ;
        endcase
      end
    end
  end

  assign cur_ptr = ptr_q[sel];
endmodule

// File: rtl/dptr_offset.sv
module dptr_offset
  import dptr_pkg::*;
#(
  parameter int W = PTR_W
) (
  input  logic [W-1:0]      base,
  input  logic [BYTE_W-1:0] offs,
  output logic [W-1:0]      sum
);
  assign sum = base + W'(offs);
endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
  import dptr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  boot_status,
  input  logic        boot_pin,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  input  logic        sfr_we,
  input  logic        aux_inc,
  input  logic        uop_inc,
  input  logic        uop_load,
  input  logic [15:0] uop_imm,
  input  logic [7:0]  acc,
  output logic [7:0]  sfr_rdata,
  output logic [15:0] ptr_addr,
  output logic [15:0] sum_addr
);
  logic              hit_lo, hit_hi, hit_aux;
  logic              aux_sel, aux_flag, aux_boot;
  logic [BYTE_W-1:0] aux_val;
  logic [PTR_W-1:0]  cur_ptr;

  assign hit_lo  = (sfr_addr == SFR_PTR_LO);
  assign hit_hi  = (sfr_addr == SFR_PTR_HI);
  assign hit_aux = (sfr_addr == SFR_AUX);

  dptr_aux_reg u_aux (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_status (boot_status),
    .boot_pin    (boot_pin),
    .wr_en       (sfr_we & hit_aux),
    .wr_data     (sfr_wdata),
    .inc_en      (aux_inc),
    .sel_q       (aux_sel),
    .flag_q      (aux_flag),
    .boot_q      (aux_boot),
    .rd_val      (aux_val)
  );

  dptr_bank #(.W(PTR_W), .N(NUM_PTR)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (SEL_W'(aux_sel)),
    .load      (uop_load),
    .imm       (uop_imm),
    .inc       (uop_inc),
    .byte_we   (sfr_we & (hit_lo | hit_hi)),
    .byte_hi   (hit_hi),
    .byte_data (sfr_wdata),
    .cur_ptr   (cur_ptr)
  );

  dptr_offset #(.W(PTR_W)) u_offs (
    .base (cur_ptr),
    .offs (acc),
    .sum  (sum_addr)
  );

  always_comb begin
    if (hit_lo)       sfr_rdata = cur_ptr[7:0];
    else if (hit_hi)  sfr_rdata = cur_ptr[15:8];
    else if (hit_aux) sfr_rdata = aux_val;
    else              sfr_rdata = '0;
  end

  assign ptr_addr = cur_ptr;
endmodule

// File: rtl/dptr_unit_chk.sv
module dptr_unit_chk
  import dptr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sfr_addr,
  input logic        sfr_we,
  input logic [7:0]  sfr_rdata,
  input logic        aux_inc,
  input logic        uop_inc,
  input logic        uop_load,
  input logic [15:0] uop_imm,
  input logic [15:0] ptr_addr,
  input logic        sel,
  input logic        flag,
  input logic        boot
);
  logic aux_touch;
  assign aux_touch = aux_inc | (sfr_we & (sfr_addr == SFR_AUX));

  a_r5_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_inc && !uop_load && !aux_touch) |=> ptr_addr == $past(ptr_addr) + 16'd1);

  a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_load && !aux_touch) |=> ptr_addr == $past(uop_imm));

  a_r8_aux_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    aux_inc |=> (sel != $past(sel)) && (flag == $past(flag)));

  a_r2_boot_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(boot));

  a_r3_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == SFR_AUX) |-> (sfr_rdata[7:6] == 2'b00 && sfr_rdata[4] == 1'b0 &&
                               sfr_rdata[2:1] == 2'b00));

  a_r9_uop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_load && sfr_we && (sfr_addr == SFR_PTR_LO || sfr_addr == SFR_PTR_HI))
      |=> ptr_addr == $past(uop_imm));
endmodule

bind dptr_unit dptr_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sfr_addr  (sfr_addr),
  .sfr_we    (sfr_we),
  .sfr_rdata (sfr_rdata),
  .aux_inc   (aux_inc),
  .uop_inc   (uop_inc),
  .uop_load  (uop_load),
  .uop_imm   (uop_imm),
  .ptr_addr  (ptr_addr),
  .sel       (aux_sel),
  .flag      (aux_flag),
  .boot      (aux_boot)
);

// File: tb/dptr_unit_test.sv
module dptr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  boot_status = '0;
  logic        boot_pin = 1'b0;
  logic [7:0]  sfr_addr = '0;
  logic [7:0]  sfr_wdata = '0;
  logic        sfr_we = 1'b0;
  logic        aux_inc = 1'b0;
  logic        uop_inc = 1'b0;
  logic        uop_load = 1'b0;
  logic [15:0] uop_imm = '0;
  logic [7:0]  acc = '0;
  logic [7:0]  sfr_rdata;
  logic [15:0] ptr_addr;
  logic [15:0] sum_addr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dptr_unit uut (.*);

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    sfr_we = 0; aux_inc = 0; uop_inc = 0; uop_load = 0; sfr_addr = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset(input logic [7:0] st, input logic pin);
    @(negedge clk);
    idle_inputs();
    rst_n = 0; boot_status = st; boot_pin = pin;
    repeat (2) @(negedge clk);
    rst_n = 1;
    boot_status = ~st; boot_pin = ~pin;
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1;
    step();
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a;
    #1 d = sfr_rdata;
  endtask

  task automatic load_ptr(input logic [15:0] v);
    @(negedge clk);
    uop_load = 1; uop_imm = v;
    step();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset(8'h00, 1'b0);
    sfr_read(8'h82, d); check("R1 low byte", 16'(d), 16'h00);
    sfr_read(8'h83, d); check("R1 high byte", 16'(d), 16'h00);
    check("R1 ptr_addr", ptr_addr, 16'h0000);
    sfr_read(8'hA2, d); check("R1/R2 aux clear", 16'(d), 16'h00);
  endtask

  task automatic t_boot();
    logic [7:0] d;
    do_reset(8'h40, 1'b0);
    repeat (3) step();
    sfr_read(8'hA2, d); check("R2 status nonzero", 16'(d), 16'h20);
    sfr_write(8'hA2, 8'hFF);
    sfr_read(8'hA2, d); check("R3 write all ones", 16'(d), 16'h29);
    sfr_write(8'hA2, 8'h00);
    sfr_read(8'hA2, d); check("R2 boot kept after write", 16'(d), 16'h20);
    do_reset(8'h00, 1'b1);
    sfr_read(8'hA2, d); check("R2 pin set", 16'(d), 16'h20);
    do_reset(8'h00, 1'b0);
    sfr_read(8'hA2, d); check("R2 both clear", 16'(d), 16'h00);
  endtask

  task automatic t_select();
    logic [7:0] d;
    sfr_write(8'h82, 8'h34);
    sfr_write(8'h83, 8'h12);
    check("R4 ptr0 bytes", ptr_addr, 16'h1234);
    sfr_write(8'hA2, 8'h01);
    check("R4 ptr1 untouched", ptr_addr, 16'h0000);
    sfr_write(8'h82, 8'hCD);
    sfr_write(8'h83, 8'hAB);
    sfr_read(8'h83, d); check("R4 ptr1 high read", 16'(d), 16'hAB);
    sfr_write(8'hA2, 8'h00);
    check("R4 ptr0 kept", ptr_addr, 16'h1234);
    sfr_read(8'h82, d); check("R4 ptr0 low read", 16'(d), 16'h34);
  endtask

  task automatic t_load_inc();
    load_ptr(16'hFFFE);
    check("R6 load", ptr_addr, 16'hFFFE);
    @(negedge clk); uop_inc = 1; step();
    check("R5 inc", ptr_addr, 16'hFFFF);
    @(negedge clk); uop_inc = 1; step();
    check("R5 wrap", ptr_addr, 16'h0000);
    @(negedge clk); uop_inc = 1; uop_load = 1; uop_imm = 16'h5555; step();
    check("R10 load beats inc", ptr_addr, 16'h5555);
  endtask

  task automatic t_sum();
    load_ptr(16'hFFF0);
    @(negedge clk); acc = 8'h20; #1;
    check("R7 wrap sum", sum_addr, 16'h0010);
    acc = 8'h00; #1;
    check("R7 zero acc", sum_addr, 16'hFFF0);
    acc = 8'h0F; #1;
    check("R7 top", sum_addr, 16'hFFFF);
  endtask

  task automatic t_aux_inc();
    logic [7:0] d;
    sfr_write(8'hA2, 8'h08);
    @(negedge clk); aux_inc = 1; step();
    sfr_read(8'hA2, d); check("R8 inc sets sel", 16'(d), 16'h09);
    @(negedge clk); aux_inc = 1; step();
    sfr_read(8'hA2, d); check("R8 inc keeps flag", 16'(d), 16'h08);
    @(negedge clk); aux_inc = 1; sfr_we = 1; sfr_addr = 8'hA2; sfr_wdata = 8'h00; step();
    sfr_read(8'hA2, d); check("R10 aux inc beats write", 16'(d), 16'h09);
    sfr_write(8'hA2, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    load_ptr(16'h1111);
    @(negedge clk); uop_inc = 1; sfr_we = 1; sfr_addr = 8'h82; sfr_wdata = 8'hEE; step();
    sfr_read(8'h82, d); check("R9 inc beats low write", 16'(d), 16'h12);
    @(negedge clk); uop_load = 1; uop_imm = 16'h2222; sfr_we = 1; sfr_addr = 8'h83; sfr_wdata = 8'h99; step();
    sfr_read(8'h83, d); check("R9 load beats high write", 16'(d), 16'h22);
    sfr_write(8'hA2, 8'h01);
    check("R9 other pointer intact", ptr_addr, 16'hABCD);
    sfr_write(8'hA2, 8'h00);
  endtask

  task automatic t_other();
    logic [7:0] d;
    sfr_write(8'h81, 8'hFF);
    sfr_write(8'h84, 8'h55);
    sfr_read(8'h81, d); check("R11 unmapped read", 16'(d), 16'h00);
    check("R11 pointer unchanged", ptr_addr, 16'h2222);
    sfr_read(8'hA2, d); check("R11 aux unchanged", 16'(d), 16'h00);
  endtask

  initial begin
    t_reset();
    t_boot();
    t_select();
    t_load_inc();
    t_sum();
    t_aux_inc();
    t_priority();
    t_other();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule